// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block turns groups of output clocks off and on in response to asynchronous, active-low stop requests. There are two groups. A processor group of gated clocks is controlled by one request, and a peripheral group by another. Next to the peripheral group sit an early peripheral output, driven from its own leading source clock, and a free-running peripheral output. Neither of these two outputs responds to the peripheral stop request.

Each request first passes through a chain of flip-flops on the falling edge of the clock it controls. The gate enable therefore changes only while that source clock is low. A stopped output parks at 0. A restarted output begins with a complete high phase. Each group also reports a status flag that is set while its outputs are parked.

Top module: `clk_stop_gate`

## Requirements
- R1: Each stop request is synchronized by falling-edge flip-flops in its own domain before it acts. The processor chain is 3 deep (CPU_SYNC) and the peripheral chain is 2 deep (PCI_SYNC).
- R2: A gated output is never high while its source clock is low, and a stopped output stays at logic 0.
- R3: If the processor request falls during a high phase of its source, exactly 2 further full pulses appear on the processor outputs, and then they stay low. The stop latency is under 4 cycles.
- R4: If the processor request rises during a high phase of its source, the next 2 rising source edges give no pulse. The 3rd rising edge gives a full-width pulse of half the source period.
- R5: If the peripheral request falls during a high phase of its source, exactly 1 further full pulse appears on the peripheral outputs, and then they stay low.
- R6: If the peripheral request rises during a high phase of its source, the next rising source edge gives no pulse. The 2nd rising edge gives a full-width pulse.
- R7: The early output and the free-running output give one pulse per rising edge of their sources whatever the peripheral request does.
- R8: While one group is stopped, the other group's outputs keep giving one pulse per source rising edge.
- R9: A group's status flag is 1 from the falling source edge that ends its first suppressed high phase. It returns to 0 at the falling source edge that ends the first full pulse after a restart.
- R10: While reset is low, every clock output and both status flags are 0. After reset, with both requests high, all outputs run.
- R11: All outputs of a group switch together; the group's bus is always all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| cpuClk | input | 1 | Processor group source clock |
| pciClk | input | 1 | Peripheral group source clock |
| pciEarlyClk | input | 1 | Leading source for the early peripheral output |
| cpuStopN | input | 1 | Asynchronous active-low processor stop request |
| pciStopN | input | 1 | Asynchronous active-low peripheral stop request |
| cpuClkOut | output | CPU_WIDTH | Gated processor clocks |
| pciClkOut | output | PCI_WIDTH | Gated peripheral clocks |
| pciEarlyOut | output | 1 | Early peripheral clock, never stopped |
| pciFreeOut | output | 1 | Free-running peripheral clock |
| cpuStopped | output | 1 | Processor group parked flag |
| pciStopped | output | 1 | Peripheral group parked flag |

## Verification
The assertions assume three things about the inputs: reset is asserted only at start-up, each source clock keeps a steady period, and the requests may change at any instant. The stimulus keeps to this. Directed cases change a request 2 ns after a rising edge, so the pulse counts and latencies are exact. Random cases change the requests at arbitrary times, and then hold them for at least ten processor cycles before the outputs are counted.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  // strobes from a control unit to its gating datapath
  typedef struct packed {
    logic run;   // domain out of reset
    logic pass;  // synchronized request says "running"
  } gateCtlT;
endpackage

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    stopN,
  output gateCtlT ctl,
  output logic    stopped
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] syncQ;
  logic          runQ;
  logic          stoppedQ;

  // all state moves on the falling edge, so the gate changes only while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      runQ     <= 1'b0;
      stoppedQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[LAST-1:0], stopN};
      runQ     <= 1'b1;
      // old gate value: was the high phase that just ended suppressed?
      stoppedQ <= runQ & ~syncQ[LAST];
    end
  end

  assign ctl.run  = runQ;
  assign ctl.pass = syncQ[LAST];
  assign stopped  = stoppedQ;
endmodule

// File: rtl/clk_gate_path.sv
module clk_gate_path
  import clk_stop_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  gateCtlT          ctl,
  output logic [WIDTH-1:0] clkOut
);
  logic open;
  assign open = ctl.run & ctl.pass;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign clkOut[i] = clk & open;
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int CPU_WIDTH = 3,
  parameter int PCI_WIDTH = 5,
  parameter int CPU_SYNC  = 3,
  parameter int PCI_SYNC  = 2
) (
  input  logic                 rstN,
  input  logic                 cpuClk,
  input  logic                 pciClk,
  input  logic                 pciEarlyClk,
  input  logic                 cpuStopN,
  input  logic                 pciStopN,
  output logic [CPU_WIDTH-1:0] cpuClkOut,
  output logic [PCI_WIDTH-1:0] pciClkOut,
  output logic                 pciEarlyOut,
  output logic                 pciFreeOut,
  output logic                 cpuStopped,
  output logic                 pciStopped
);
  gateCtlT cpuCtl, pciCtl, earlyCtl, freeCtl;
  logic    earlyStatusUnused;

  clk_stop_ctrl #(.STAGES(CPU_SYNC)) u_cpuCtrl (
    .clk(cpuClk), .rstN(rstN), .stopN(cpuStopN), .ctl(cpuCtl), .stopped(cpuStopped)
  );
  clk_gate_path #(.WIDTH(CPU_WIDTH)) u_cpuPath (
    .clk(cpuClk), .ctl(cpuCtl), .clkOut(cpuClkOut)
  );

  clk_stop_ctrl #(.STAGES(PCI_SYNC)) u_pciCtrl (
    .clk(pciClk), .rstN(rstN), .stopN(pciStopN), .ctl(pciCtl), .stopped(pciStopped)
  );
  clk_gate_path #(.WIDTH(PCI_WIDTH)) u_pciPath (
    .clk(pciClk), .ctl(pciCtl), .clkOut(pciClkOut)
  );

  // early output: own domain, request tied to "run"
  clk_stop_ctrl #(.STAGES(PCI_SYNC)) u_earlyCtrl (
    .clk(pciEarlyClk), .rstN(rstN), .stopN(1'b1), .ctl(earlyCtl), .stopped(earlyStatusUnused)
  );
  clk_gate_path #(.WIDTH(1)) u_earlyPath (
    .clk(pciEarlyClk), .ctl(earlyCtl), .clkOut(pciEarlyOut)
  );

  // free-running output: only the reset hold applies
  assign freeCtl.run  = pciCtl.run;
  assign freeCtl.pass = 1'b1;
  clk_gate_path #(.WIDTH(1)) u_freePath (
    .clk(pciClk), .ctl(freeCtl), .clkOut(pciFreeOut)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int CPU_WIDTH = 3,
  parameter int PCI_WIDTH = 5
) (
  input logic                 rstN,
  input logic                 cpuClk,
  input logic                 pciClk,
  input logic [CPU_WIDTH-1:0] cpuClkOut,
  input logic [PCI_WIDTH-1:0] pciClkOut,
  input logic                 pciFreeOut,
  input logic                 cpuStopped,
  input logic                 pciStopped
);
  // R2: just before a rising source edge the gated outputs are low
  a_r2_cpu_low_phase: assert property (@(posedge cpuClk) disable iff (!rstN)
    cpuClkOut == '0);
  a_r2_pci_low_phase: assert property (@(posedge pciClk) disable iff (!rstN)
    pciClkOut == '0);

  // R9: a delivered high phase clears the status at its falling edge
  a_r9_cpu_status_clear: assert property (@(negedge cpuClk) disable iff (!rstN)
    cpuClkOut[0] |=> !cpuStopped);
  a_r9_pci_status_clear: assert property (@(negedge pciClk) disable iff (!rstN)
    pciClkOut[0] |=> !pciStopped);

  // R7: the free-running output pulses even while its group is parked
  a_r7_free_runs: assert property (@(negedge pciClk) disable iff (!rstN)
    pciStopped |-> pciFreeOut);

  // R11: group bits move together
  a_r11_cpu_lockstep: assert property (@(negedge cpuClk) disable iff (!rstN)
    (cpuClkOut == '0) || (cpuClkOut == '1));
  a_r11_pci_lockstep: assert property (@(negedge pciClk) disable iff (!rstN)
    (pciClkOut == '0) || (pciClkOut == '1));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.CPU_WIDTH(CPU_WIDTH), .PCI_WIDTH(PCI_WIDTH)) u_chk (.*);

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
  localparam int CW = 3, PW = 5, CS = 3, PS = 2;

  logic rstN = 1'b0, cpuClk = 1'b0, pciClk = 1'b0, pciEarlyClk = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1;
  logic [CW-1:0] cpuClkOut;
  logic [PW-1:0] pciClkOut;
  logic pciEarlyOut, pciFreeOut, cpuStopped, pciStopped;

  int vectors = 0, miscompares = 0;
  int cpuPulses = 0, pciPulses = 0, earlyPulses = 0, freePulses = 0;
  int pciEdges = 0, earlyEdges = 0;
  realtime cpuRiseT = 0, pciRiseT = 0, cpuWidth = 0, pciWidth = 0;

  clk_stop_gate #(.CPU_WIDTH(CW), .PCI_WIDTH(PW), .CPU_SYNC(CS), .PCI_SYNC(PS)) i_clk_stop_gate (.*);

  initial forever #10 cpuClk = ~cpuClk;                  // 50 MHz
  initial begin #4 forever begin pciClk = ~pciClk; #15; end end
  initial begin #1 forever begin pciEarlyClk = ~pciEarlyClk; #15; end end

  always @(posedge cpuClkOut[0]) begin cpuPulses++; cpuRiseT = $realtime; end
  always @(negedge cpuClkOut[0]) cpuWidth = $realtime - cpuRiseT;
  always @(posedge pciClkOut[0]) begin pciPulses++; pciRiseT = $realtime; end
  always @(negedge pciClkOut[0]) pciWidth = $realtime - pciRiseT;
  always @(posedge pciEarlyOut) earlyPulses++;
  always @(posedge pciFreeOut) freePulses++;
  always @(posedge pciClk) pciEdges++;
  always @(posedge pciEarlyClk) earlyEdges++;

  function automatic int expPulses(bit runReq, int n);
    return runReq ? n : 0;
  endfunction
  function automatic int expStopTail(int stages);
    return stages - 1;   // full pulses left after a request seen in a high phase
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic cpuTick(); @(posedge cpuClk); #2; endtask
  task automatic pciTick(); @(posedge pciClk); #2; endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int c0, p0, e0, f0, pe0, ee0, first;
    // R10: reset hold, sampled while every source is high
    #13;
    chk("R10 cpu out in reset", int'(cpuClkOut), 0);
    chk("R10 pci out in reset", int'(pciClkOut), 0);
    chk("R10 early/free in reset", int'({pciEarlyOut, pciFreeOut}), 0);
    chk("R10 status in reset", int'({cpuStopped, pciStopped}), 0);
    #32 rstN = 1'b1;
    repeat (3) cpuTick();
    c0 = cpuPulses; p0 = pciPulses;
    repeat (4) cpuTick();
    chk("R10 cpu runs after reset", cpuPulses - c0, 4);
    chk("R11 cpu bus all ones", int'(cpuClkOut), (1 << CW) - 1);

    // R3/R1/R8: processor stop seen during a high phase
    cpuTick();
    c0 = cpuPulses; p0 = pciPulses; pe0 = pciEdges;
    cpuStopN = 1'b0;
    repeat (8) cpuTick();
    chk("R3 cpu tail pulses", cpuPulses - c0, expStopTail(CS));
    chk("R3 cpu tail under 4", int'(cpuPulses - c0 < 4), 1);
    chk("R2 cpu parked low", int'(cpuClkOut), 0);
    chk("R9 cpu status set", int'(cpuStopped), 1);
    chk("R8 pci undisturbed", pciPulses - p0, pciEdges - pe0);

    // R4/R9: processor restart
    cpuTick();
    c0 = cpuPulses; first = 0;
    cpuStopN = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      cpuTick();
      if (first == 0 && cpuPulses > c0) first = n;
      if (n == CS) chk("R9 cpu status held in first pulse", int'(cpuStopped), 1);
      if (n == CS + 1) chk("R9 cpu status cleared", int'(cpuStopped), 0);
    end
    chk("R4 cpu restart edge", first, CS);
    chk("R4 cpu first pulse width", int'(cpuWidth), 10);

    // R5/R7/R8: peripheral stop
    pciTick();
    p0 = pciPulses; c0 = cpuPulses; e0 = earlyPulses; f0 = freePulses;
    pe0 = pciEdges; ee0 = earlyEdges;
    pciStopN = 1'b0;
    repeat (6) pciTick();
    chk("R5 pci tail pulses", pciPulses - p0, expStopTail(PS));
    chk("R2 pci parked low", int'(pciClkOut), 0);
    chk("R9 pci status set", int'(pciStopped), 1);
    chk("R7 free output runs", freePulses - f0, pciEdges - pe0);
    chk("R7 early output runs", earlyPulses - e0, earlyEdges - ee0);
    chk("R8 cpu undisturbed", int'(cpuPulses - c0 >= 8), 1);

    // R6: peripheral restart
    pciTick();
    p0 = pciPulses; first = 0;
    pciStopN = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      pciTick();
      if (first == 0 && pciPulses > p0) first = n;
      if (n == PS + 1) chk("R9 pci status cleared", int'(pciStopped), 0);
    end
    chk("R6 pci restart edge", first, PS);
    chk("R6 pci first pulse width", int'(pciWidth), 15);

    // R1/R2/R7/R8/R9: random request changes at arbitrary instants
    void'($urandom(32'h5eed));
    for (int it = 0; it < 40; it++) begin
      bit cReq, pReq;
      cReq = 1'($urandom_range(0, 1));
      pReq = 1'($urandom_range(0, 1));
      #($urandom_range(0, 40));
      cpuStopN = cReq;
      #($urandom_range(0, 17));
      pciStopN = pReq;
      repeat (10) cpuTick();
      c0 = cpuPulses;
      repeat (4) cpuTick();
      chk("R8 random cpu pulses", cpuPulses - c0, expPulses(cReq, 4));
      chk("R9 random cpu status", int'(cpuStopped), int'(!cReq));
      pciTick();
      p0 = pciPulses; f0 = freePulses;
      repeat (4) pciTick();
      chk("R5 random pci pulses", pciPulses - p0, expPulses(pReq, 4));
      chk("R9 random pci status", int'(pciStopped), int'(!pReq));
      chk("R7 random free pulses", freePulses - f0, 4);
    end
    summary();
  end
endmodule